// File: doc/BRIEF.md
# Out-of-Order Issue Scheduler with Tag Renaming

This block sits between an in-order instruction front end and a set of functional units (add, multiply, load/store). Each accepted instruction is placed in a free station of the matching unit type. The destination register is renamed to that station's tag. Each source operand is either copied as a value or recorded as the tag of the station that will produce it. Once renaming has been done, later writers and readers of a register no longer block one another. Only true data dependences and a shortage of stations can hold up issue.

The functional units are outside the block. When a station has both operands and its unit grants, the block sends the opcode, the operands and the immediate to that unit. Each unit returns a tag and a value. One internal result bus is shared by all units: each cycle it carries one completed result to every waiting station and to the register status table. The register file is also outside the block. The block reads the register file through two combinational ports and writes it back through one port.

Top module: `rs_sched`

## Requirements
- R1: After reset no station is occupied. No unit request is raised, no result bus cycle occurs, and issue is accepted for each valid unit code.
- R2: Unit codes are 0 for add, 1 for multiply and 2 for load/store. `in_ready` is low when every station of the requested type is occupied, and it is always low for unit code 3.
- R3: Station tags are numbered from 1: the add stations first, then the multiply stations, then the load/store stations. Tag 0 means "no producer". An issue takes the lowest-numbered free station of its type.
- R4: Each value broadcast on the result bus equals the in-order result of the instruction that owns the tag, even when registers are reused (write-after-read and write-after-write reuse). Results are: add is a+b when op bit 0 is 0 and a−b when it is 1; multiply is the low half of a·b; load/store is a+imm.
- R5: When a result is broadcast in the same cycle that an instruction issues and reads that tag, the issuing station captures the broadcast value and needs no further wait.
- R6: A station raises its unit request only when it holds both operand values and has not yet been sent. Among such stations of one type, the lowest-numbered one is offered.
- R7: At most one result uses the bus per cycle. The lowest unit code with a pending result wins and is acknowledged. Any other unit gets no acknowledge and keeps its result.
- R8: When a broadcast tag equals the current producer tag of a register, that register is written back in the same cycle and its producer tag is cleared.
- R9: A station becomes free in the cycle after its result is broadcast, and it can be allocated again from then on.
- R10: A register that has been renamed again to a newer producer is never written back by an older producer. After the block drains, the register file matches in-order execution.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An instruction is offered |
| in_ready | output | 1 | The offered instruction is accepted this cycle |
| in_unit | input | 2 | Unit type code (0 add, 1 multiply, 2 load/store) |
| in_op | input | OPW | Operation code passed to the unit |
| in_dst | input | RW | Destination register |
| in_src1 | input | RW | First source register |
| in_src2 | input | RW | Second source register |
| in_wr | input | 1 | Instruction writes its destination |
| in_imm | input | XLEN | Immediate or address offset |
| rf_raddr1 | output | RW | Register file read address 1 |
| rf_raddr2 | output | RW | Register file read address 2 |
| rf_rdata1 | input | XLEN | Register file read data 1 |
| rf_rdata2 | input | XLEN | Register file read data 2 |
| rf_we | output | 1 | Register file write enable |
| rf_waddr | output | RW | Register file write address |
| rf_wdata | output | XLEN | Register file write data |
| ex_req | output | 3 | Per-unit dispatch request |
| ex_grant | input | 3 | Per-unit ready to accept |
| ex_tag | output | 3·TAGW | Per-unit tag of the dispatched station |
| ex_op | output | 3·OPW | Per-unit operation code |
| ex_vj | output | 3·XLEN | Per-unit first operand |
| ex_vk | output | 3·XLEN | Per-unit second operand |
| ex_a | output | 3·XLEN | Per-unit immediate |
| res_valid | input | 3 | Per-unit result pending |
| res_tag | input | 3·TAGW | Per-unit result tag |
| res_data | input | 3·XLEN | Per-unit result value |
| res_ack | output | 3 | Per-unit result taken this cycle |
| cdb_valid | output | 1 | Result bus carries a result |
| cdb_tag | output | TAGW | Result bus tag |
| cdb_data | output | XLEN | Result bus value |

## Verification
The bench uses the default parameters: three add, two multiply and two load/store stations, eight registers and 16-bit data. At these sizes, random traffic over eight registers keeps the banks full most of the time. As a result, issue stalls, immediate tag reuse and heavy register renaming all occur in a few thousand cycles. Unit latencies of one, two and four cycles, together with randomly withheld grants, make results from different units meet on the bus. They also make broadcasts coincide with issues that read the same tag.

// File: rtl/rs_pkg.sv
package rs_pkg;
  localparam int NUNIT = 3;
  localparam logic [1:0] UNIT_ADD = 2'd0;
  localparam logic [1:0] UNIT_MUL = 2'd1;
  localparam logic [1:0] UNIT_LS  = 2'd2;
endpackage

// File: rtl/rs_bank.sv
module rs_bank #(
  parameter int N    = 2,
  parameter int BASE = 1,
  parameter int XLEN = 16,
  parameter int OPW  = 3,
  parameter int TAGW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            alloc,
  input  logic [OPW-1:0]  alloc_op,
  input  logic [XLEN-1:0] alloc_vj,
  input  logic [XLEN-1:0] alloc_vk,
  input  logic [XLEN-1:0] alloc_a,
  input  logic [TAGW-1:0] alloc_qj,
  input  logic [TAGW-1:0] alloc_qk,
  output logic            has_free,
  output logic [TAGW-1:0] free_tag,
  input  logic            cdb_valid,
  input  logic [TAGW-1:0] cdb_tag,
  input  logic [XLEN-1:0] cdb_data,
  output logic            req,
  input  logic            grant,
  output logic [TAGW-1:0] req_tag,
  output logic [OPW-1:0]  req_op,
  output logic [XLEN-1:0] req_vj,
  output logic [XLEN-1:0] req_vk,
  output logic [XLEN-1:0] req_a
);
  logic [N-1:0]    busy_q, busy_d, run_q, run_d;
  logic [OPW-1:0]  op_q [N];
  logic [OPW-1:0]  op_d [N];
  logic [XLEN-1:0] vj_q [N];
  logic [XLEN-1:0] vj_d [N];
  logic [XLEN-1:0] vk_q [N];
  logic [XLEN-1:0] vk_d [N];
  logic [XLEN-1:0] a_q  [N];
  logic [XLEN-1:0] a_d  [N];
  logic [TAGW-1:0] qj_q [N];
  logic [TAGW-1:0] qj_d [N];
  logic [TAGW-1:0] qk_q [N];
  logic [TAGW-1:0] qk_d [N];
  int fidx, ridx;

  // lowest free slot and lowest ready slot
  always_comb begin
    has_free = 1'b0;
    fidx     = 0;
    req      = 1'b0;
    ridx     = 0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!busy_q[i]) begin
        has_free = 1'b1;
        fidx     = i;
      end
      if (busy_q[i] && !run_q[i] && qj_q[i] == '0 && qk_q[i] == '0) begin
        req  = 1'b1;
        ridx = i;
      end
    end
    free_tag = TAGW'(BASE + fidx);
    req_tag  = TAGW'(BASE + ridx);
    req_op   = op_q[ridx];
    req_vj   = vj_q[ridx];
    req_vk   = vk_q[ridx];
    req_a    = a_q[ridx];
  end

  // next state: snoop, dispatch, release, allocate
  always_comb begin
    busy_d = busy_q;
    run_d  = run_q;
    op_d   = op_q;
    vj_d   = vj_q;
    vk_d   = vk_q;
    a_d    = a_q;
    qj_d   = qj_q;
    qk_d   = qk_q;
    for (int i = 0; i < N; i++) begin
      if (cdb_valid && busy_q[i]) begin
        if (qj_q[i] != '0 && qj_q[i] == cdb_tag) begin
          qj_d[i] = '0;
          vj_d[i] = cdb_data;
        end
        if (qk_q[i] != '0 && qk_q[i] == cdb_tag) begin
          qk_d[i] = '0;
          vk_d[i] = cdb_data;
        end
        if (run_q[i] && cdb_tag == TAGW'(BASE + i)) begin
          busy_d[i] = 1'b0;
          run_d[i]  = 1'b0;
        end
      end
      if (grant && req && i == ridx) run_d[i] = 1'b1;
      if (alloc && i == fidx) begin
        busy_d[i] = 1'b1;
        run_d[i]  = 1'b0;
        op_d[i]   = alloc_op;
        vj_d[i]   = alloc_vj;
        vk_d[i]   = alloc_vk;
        a_d[i]    = alloc_a;
        qj_d[i]   = alloc_qj;
        qk_d[i]   = alloc_qk;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= '0;
      run_q  <= '0;
    end else begin
      busy_q <= busy_d;
      run_q  <= run_d;
    end
  end

  // payload only meaningful while busy, so it carries no reset
  always_ff @(posedge clk) begin
    op_q <= op_d;
    vj_q <= vj_d;
    vk_q <= vk_d;
    a_q  <= a_d;
    qj_q <= qj_d;
    qk_q <= qk_d;
  end
endmodule

// File: rtl/rs_regstat.sv
module rs_regstat #(
  parameter int NREG = 8,
  parameter int TAGW = 3,
  parameter int XLEN = 16,
  parameter int RW   = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [RW-1:0]   rd1,
  input  logic [RW-1:0]   rd2,
  output logic [TAGW-1:0] q1,
  output logic [TAGW-1:0] q2,
  input  logic            set_en,
  input  logic [RW-1:0]   set_reg,
  input  logic [TAGW-1:0] set_tag,
  input  logic            cdb_valid,
  input  logic [TAGW-1:0] cdb_tag,
  input  logic [XLEN-1:0] cdb_data,
  output logic            wb_en,
  output logic [RW-1:0]   wb_reg,
  output logic [XLEN-1:0] wb_data
);
  logic [TAGW-1:0] qi_q [NREG];
  logic [TAGW-1:0] qi_d [NREG];

  assign q1      = qi_q[rd1];
  assign q2      = qi_q[rd2];
  assign wb_data = cdb_data;

  always_comb begin
    wb_en  = 1'b0;
    wb_reg = '0;
    qi_d   = qi_q;
    for (int r = NREG - 1; r >= 0; r--) begin
      if (cdb_valid && cdb_tag != '0 && qi_q[r] == cdb_tag) begin
        wb_en   = 1'b1;
        wb_reg  = RW'(r);
        qi_d[r] = '0;
      end
    end
    // a new rename overrides the clear of the same register
    if (set_en) qi_d[set_reg] = set_tag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NREG; r++) qi_q[r] <= '0;
    end else begin
      qi_q <= qi_d;
    end
  end
endmodule

// File: rtl/rs_cdb_arb.sv
module rs_cdb_arb #(
  parameter int NU   = 3,
  parameter int TAGW = 3,
  parameter int XLEN = 16
) (
  input  logic [NU-1:0]      res_valid,
  input  logic [NU*TAGW-1:0] res_tag,
  input  logic [NU*XLEN-1:0] res_data,
  output logic [NU-1:0]      res_ack,
  output logic               cdb_valid,
  output logic [TAGW-1:0]    cdb_tag,
  output logic [XLEN-1:0]    cdb_data
);
  always_comb begin
    res_ack   = '0;
    cdb_valid = 1'b0;
    cdb_tag   = '0;
    cdb_data  = '0;
    for (int u = NU - 1; u >= 0; u--) begin
      if (res_valid[u]) begin
        res_ack    = '0;
        res_ack[u] = 1'b1;
        cdb_valid  = 1'b1;
        cdb_tag    = res_tag[u*TAGW +: TAGW];
        cdb_data   = res_data[u*XLEN +: XLEN];
      end
    end
  end
endmodule

// File: rtl/rs_sched.sv
module rs_sched
  import rs_pkg::*;
#(
  parameter int XLEN  = 16,
  parameter int NREG  = 8,
  parameter int OPW   = 3,
  parameter int N_ADD = 3,
  parameter int N_MUL = 2,
  parameter int N_LS  = 2,
  localparam int RW   = $clog2(NREG),
  localparam int TAGW = $clog2(N_ADD + N_MUL + N_LS + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [1:0]            in_unit,
  input  logic [OPW-1:0]        in_op,
  input  logic [RW-1:0]         in_dst,
  input  logic [RW-1:0]         in_src1,
  input  logic [RW-1:0]         in_src2,
  input  logic                  in_wr,
  input  logic [XLEN-1:0]       in_imm,
  output logic [RW-1:0]         rf_raddr1,
  output logic [RW-1:0]         rf_raddr2,
  input  logic [XLEN-1:0]       rf_rdata1,
  input  logic [XLEN-1:0]       rf_rdata2,
  output logic                  rf_we,
  output logic [RW-1:0]         rf_waddr,
  output logic [XLEN-1:0]       rf_wdata,
  output logic [NUNIT-1:0]      ex_req,
  input  logic [NUNIT-1:0]      ex_grant,
  output logic [NUNIT*TAGW-1:0] ex_tag,
  output logic [NUNIT*OPW-1:0]  ex_op,
  output logic [NUNIT*XLEN-1:0] ex_vj,
  output logic [NUNIT*XLEN-1:0] ex_vk,
  output logic [NUNIT*XLEN-1:0] ex_a,
  input  logic [NUNIT-1:0]      res_valid,
  input  logic [NUNIT*TAGW-1:0] res_tag,
  input  logic [NUNIT*XLEN-1:0] res_data,
  output logic [NUNIT-1:0]      res_ack,
  output logic                  cdb_valid,
  output logic [TAGW-1:0]       cdb_tag,
  output logic [XLEN-1:0]       cdb_data
);
  logic [TAGW-1:0]  q1, q2, new_tag, oj_q, ok_q;
  logic [XLEN-1:0]  oj_v, ok_v;
  logic [NUNIT-1:0] bank_free, alloc;
  logic [TAGW-1:0]  free_tag [NUNIT];
  logic             issue_fire;

  assign rf_raddr1 = in_src1;
  assign rf_raddr2 = in_src2;

  always_comb begin
    in_ready = 1'b0;
    new_tag  = '0;
    for (int u = 0; u < NUNIT; u++) begin
      if (in_unit == 2'(u)) begin
        in_ready = bank_free[u];
        new_tag  = free_tag[u];
      end
    end
    issue_fire = in_valid && in_ready;
    for (int u = 0; u < NUNIT; u++) alloc[u] = issue_fire && in_unit == 2'(u);
  end

  // operand capture with same-cycle bypass from the result bus
  always_comb begin
    oj_q = (q1 != '0 && !(cdb_valid && cdb_tag == q1)) ? q1 : '0;
    ok_q = (q2 != '0 && !(cdb_valid && cdb_tag == q2)) ? q2 : '0;
    oj_v = (q1 == '0) ? rf_rdata1 : cdb_data;
    ok_v = (q2 == '0) ? rf_rdata2 : cdb_data;
  end

  for (genvar g = 0; g < NUNIT; g++) begin : g_bank
    localparam int NB   = (g == 0) ? N_ADD : (g == 1) ? N_MUL : N_LS;
    localparam int BASE = (g == 0) ? 1 : (g == 1) ? 1 + N_ADD : 1 + N_ADD + N_MUL;
    rs_bank #(.N(NB), .BASE(BASE), .XLEN(XLEN), .OPW(OPW), .TAGW(TAGW)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .alloc    (alloc[g]),
      .alloc_op (in_op),
      .alloc_vj (oj_v),
      .alloc_vk (ok_v),
      .alloc_a  (in_imm),
      .alloc_qj (oj_q),
      .alloc_qk (ok_q),
      .has_free (bank_free[g]),
      .free_tag (free_tag[g]),
      .cdb_valid(cdb_valid),
      .cdb_tag  (cdb_tag),
      .cdb_data (cdb_data),
      .req      (ex_req[g]),
      .grant    (ex_grant[g]),
      .req_tag  (ex_tag[g*TAGW +: TAGW]),
      .req_op   (ex_op[g*OPW +: OPW]),
      .req_vj   (ex_vj[g*XLEN +: XLEN]),
      .req_vk   (ex_vk[g*XLEN +: XLEN]),
      .req_a    (ex_a[g*XLEN +: XLEN])
    );
  end

  rs_cdb_arb #(.NU(NUNIT), .TAGW(TAGW), .XLEN(XLEN)) u_arb (
    .res_valid(res_valid),
    .res_tag  (res_tag),
    .res_data (res_data),
    .res_ack  (res_ack),
    .cdb_valid(cdb_valid),
    .cdb_tag  (cdb_tag),
    .cdb_data (cdb_data)
  );

  rs_regstat #(.NREG(NREG), .TAGW(TAGW), .XLEN(XLEN), .RW(RW)) u_regstat (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd1      (in_src1),
    .rd2      (in_src2),
    .q1       (q1),
    .q2       (q2),
    .set_en   (issue_fire && in_wr),
    .set_reg  (in_dst),
    .set_tag  (new_tag),
    .cdb_valid(cdb_valid),
    .cdb_tag  (cdb_tag),
    .cdb_data (cdb_data),
    .wb_en    (rf_we),
    .wb_reg   (rf_waddr),
    .wb_data  (rf_wdata)
  );
endmodule

// File: rtl/rs_sched_chk.sv
module rs_sched_chk
  import rs_pkg::*;
#(
  parameter int TAGW  = 3,
  parameter int XLEN  = 16,
  parameter int N_ADD = 3,
  parameter int N_MUL = 2,
  parameter int N_LS  = 2
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [1:0]            in_unit,
  input logic                  in_ready,
  input logic [NUNIT-1:0]      ex_req,
  input logic [NUNIT*TAGW-1:0] ex_tag,
  input logic [NUNIT-1:0]      res_valid,
  input logic [NUNIT-1:0]      res_ack,
  input logic                  cdb_valid,
  input logic [XLEN-1:0]       cdb_data,
  input logic                  rf_we,
  input logic [XLEN-1:0]       rf_wdata
);
  a_r7_single_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(res_ack));

  a_r7_bus_when_pending: assert property (@(posedge clk) disable iff (!rst_n)
    cdb_valid == (|res_valid));

  a_r8_wb_from_bus: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> (cdb_valid && rf_wdata == cdb_data));

  a_r2_bad_unit_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    in_unit == 2'd3 |-> !in_ready);

  for (genvar g = 0; g < NUNIT; g++) begin : g_unit
    localparam int LO = (g == 0) ? 1 : (g == 1) ? 1 + N_ADD : 1 + N_ADD + N_MUL;
    localparam int HI = LO - 1 + ((g == 0) ? N_ADD : (g == 1) ? N_MUL : N_LS);
    a_r3_tag_in_bank: assert property (@(posedge clk) disable iff (!rst_n)
      ex_req[g] |-> (ex_tag[g*TAGW +: TAGW] >= TAGW'(LO) && ex_tag[g*TAGW +: TAGW] <= TAGW'(HI)));
    a_r7_ack_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
      res_ack[g] |-> res_valid[g]);
  end
endmodule

bind rs_sched rs_sched_chk #(
  .TAGW(TAGW), .XLEN(XLEN), .N_ADD(N_ADD), .N_MUL(N_MUL), .N_LS(N_LS)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_unit  (in_unit),
  .in_ready (in_ready),
  .ex_req   (ex_req),
  .ex_tag   (ex_tag),
  .res_valid(res_valid),
  .res_ack  (res_ack),
  .cdb_valid(cdb_valid),
  .cdb_data (cdb_data),
  .rf_we    (rf_we),
  .rf_wdata (rf_wdata)
);

// File: tb/rs_sched_test.sv
module rs_sched_test;
  localparam int PERIOD = 10;
  localparam int NR = 8;
  localparam int NT = 8;

  logic clk = 1'b0;
  logic rst_n;
  always #(PERIOD/2) clk = ~clk;

  logic        in_valid, in_ready, in_wr;
  logic [1:0]  in_unit;
  logic [2:0]  in_op, in_dst, in_src1, in_src2;
  logic [15:0] in_imm;
  logic [2:0]  rf_raddr1, rf_raddr2, rf_waddr;
  logic [15:0] rf_rdata1, rf_rdata2, rf_wdata;
  logic        rf_we;
  logic [2:0]  ex_req, ex_grant, res_valid, res_ack;
  logic [8:0]  ex_tag, ex_op, res_tag;
  logic [47:0] ex_vj, ex_vk, ex_a, res_data;
  logic        cdb_valid;
  logic [2:0]  cdb_tag;
  logic [15:0] cdb_data;

  logic [15:0] rf [NR];
  assign rf_rdata1 = rf[rf_raddr1];
  assign rf_rdata2 = rf[rf_raddr2];

  rs_sched uut (.*);

  int checks = 0, errors = 0;
  bit done = 0;

  // bench model of the requirements
  bit          m_busy [NT];
  bit          m_run  [NT];
  int          m_qj [NT];
  int          m_qk [NT];
  logic [15:0] m_exp [NT];
  int          m_qi [NR];
  logic [15:0] gold [NR];
  bit          u_idle [3];
  int          u_cnt [3];
  int          u_tag [3];
  logic [15:0] u_val [3];
  bit          hold [3];
  bit          pend_we;
  int          pend_reg;
  logic [15:0] pend_val;
  int          fwd_seen = 0;

  function automatic int base_of(int u);
    return (u == 0) ? 1 : (u == 1) ? 4 : 6;
  endfunction
  function automatic int size_of(int u);
    return (u == 0) ? 3 : 2;
  endfunction
  function automatic int lat_of(int u);
    return (u == 0) ? 2 : (u == 1) ? 4 : 1;
  endfunction
  function automatic logic [15:0] calc(int u, logic [2:0] op, logic [15:0] a, logic [15:0] b, logic [15:0] imm);
    logic [31:0] p;
    p = a * b;
    case (u)
      0: return op[0] ? a - b : a + b;
      1: return p[15:0];
      default: return a + imm;
    endcase
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cycle(bit v, int un, int op, int dst, int s1, int s2, bit wr, logic [15:0] imm);
    int ftag [3];
    int win, ct, expreg, t, qa, qb, rt;
    bit found, exp_ready, fire;
    bit disp [3];
    logic [15:0] ev;
    @(negedge clk);
    if (pend_we) rf[pend_reg] = pend_val;
    pend_we = 0;
    for (int u = 0; u < 3; u++) begin
      res_valid[u] = !u_idle[u] && u_cnt[u] == 0;
      res_tag[u*3 +: 3] = 3'(u_tag[u]);
      res_data[u*16 +: 16] = u_val[u];
      ex_grant[u] = u_idle[u] && !hold[u];
    end
    in_valid = v; in_unit = 2'(un); in_op = 3'(op); in_dst = 3'(dst);
    in_src1 = 3'(s1); in_src2 = 3'(s2); in_wr = wr; in_imm = imm;
    #(PERIOD/4);
    // R6 / R3 / R9: request and offered tag per unit
    for (int u = 0; u < 3; u++) begin
      found = 0; rt = 0; ftag[u] = 0;
      for (int k = size_of(u) - 1; k >= 0; k--) begin
        t = base_of(u) + k;
        if (m_busy[t] && !m_run[t] && m_qj[t] == 0 && m_qk[t] == 0) begin found = 1; rt = t; end
        if (!m_busy[t]) ftag[u] = t;
      end
      chk(ex_req[u] == found, "R6", "unit request", ex_req[u], found);
      if (found) chk(ex_tag[u*3 +: 3] == 3'(rt), "R3/R6/R9", "offered station tag", ex_tag[u*3 +: 3], rt);
    end
    exp_ready = (un < 3) && ftag[un < 3 ? un : 0] != 0;
    chk(in_ready == exp_ready, "R2", "issue ready", in_ready, exp_ready);
    // R7: bus arbitration
    win = -1;
    for (int u = 2; u >= 0; u--) if (res_valid[u]) win = u;
    chk(cdb_valid == (win >= 0), "R7", "bus valid", cdb_valid, win >= 0);
    chk(res_ack == ((win >= 0) ? 3'(1 << win) : 3'd0), "R7", "acknowledge", res_ack, (win >= 0) ? (1 << win) : 0);
    ct = (win >= 0) ? u_tag[win] : 0;
    if (win >= 0) begin
      chk(cdb_tag == 3'(ct), "R7", "bus tag", cdb_tag, ct);
      chk(cdb_data == m_exp[ct], "R4/R5", "broadcast value", cdb_data, m_exp[ct]);
    end
    // R8: write-back
    expreg = -1;
    if (win >= 0) for (int r = NR - 1; r >= 0; r--) if (m_qi[r] == ct) expreg = r;
    chk(rf_we == (expreg >= 0), "R8/R10", "write enable", rf_we, expreg >= 0);
    if (expreg >= 0) chk(rf_waddr == 3'(expreg), "R8", "write address", rf_waddr, expreg);
    // model the coming edge
    fire = v && exp_ready;
    t = 0; qa = 0; qb = 0; ev = '0;
    if (fire) begin
      t = ftag[un];
      qa = m_qi[s1]; qb = m_qi[s2];
      if (win >= 0 && qa == ct) begin qa = 0; fwd_seen++; end
      if (win >= 0 && qb == ct) begin qb = 0; fwd_seen++; end
      ev = calc(un, 3'(op), gold[s1], gold[s2], imm);
    end
    if (win >= 0) begin
      for (int i = 1; i < NT; i++) begin
        if (m_busy[i] && m_qj[i] == ct) m_qj[i] = 0;
        if (m_busy[i] && m_qk[i] == ct) m_qk[i] = 0;
      end
      m_busy[ct] = 0; m_run[ct] = 0;
      for (int r = 0; r < NR; r++) if (m_qi[r] == ct) m_qi[r] = 0;
      u_idle[win] = 1;
    end
    if (rf_we) begin pend_we = 1; pend_reg = int'(rf_waddr); pend_val = rf_wdata; end
    if (fire) begin
      m_busy[t] = 1; m_run[t] = 0; m_qj[t] = qa; m_qk[t] = qb; m_exp[t] = ev;
      if (wr) begin m_qi[dst] = t; gold[dst] = ev; end
    end
    for (int u = 0; u < 3; u++) begin
      disp[u] = ex_req[u] && ex_grant[u];
      if (disp[u]) begin
        rt = int'(ex_tag[u*3 +: 3]);
        m_run[rt] = 1;
        u_idle[u] = 0; u_cnt[u] = lat_of(u); u_tag[u] = rt;
        u_val[u] = calc(u, ex_op[u*3 +: 3], ex_vj[u*16 +: 16], ex_vk[u*16 +: 16], ex_a[u*16 +: 16]);
      end else if (!u_idle[u] && u_cnt[u] > 0) begin
        u_cnt[u]--;
      end
    end
  endtask

  task automatic rand_cycle(bit allow);
    int un;
    un = ($urandom % 16 == 0) ? 3 : int'($urandom % 3);
    for (int u = 0; u < 3; u++) hold[u] = ($urandom % 5 == 0);
    cycle(allow && ($urandom % 10 < 7), un, int'($urandom % 8), int'($urandom % 8),
          int'($urandom % 8), int'($urandom % 8), ($urandom % 8 != 0), 16'($urandom));
  endtask

  function automatic bit idle_all();
    for (int i = 1; i < NT; i++) if (m_busy[i]) return 0;
    for (int u = 0; u < 3; u++) if (!u_idle[u]) return 0;
    return 1;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0;
    in_valid = 0; in_unit = 0; in_op = 0; in_dst = 0; in_src1 = 0; in_src2 = 0; in_wr = 0; in_imm = 0;
    ex_grant = 0; res_valid = 0; res_tag = 0; res_data = 0;
    pend_we = 0; pend_reg = 0; pend_val = 0;
    for (int r = 0; r < NR; r++) begin rf[r] = 16'(r * 37 + 5); gold[r] = rf[r]; m_qi[r] = 0; end
    for (int i = 0; i < NT; i++) begin m_busy[i] = 0; m_run[i] = 0; m_qj[i] = 0; m_qk[i] = 0; m_exp[i] = 0; end
    for (int u = 0; u < 3; u++) begin u_idle[u] = 1; u_cnt[u] = 0; u_tag[u] = 0; u_val[u] = 0; hold[u] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    #(PERIOD/4);
    // R1: reset state
    chk(ex_req == 3'd0, "R1", "requests after reset", ex_req, 0);
    chk(cdb_valid == 1'b0, "R1", "bus after reset", cdb_valid, 0);
    chk(in_ready == 1'b1, "R1", "ready after reset", in_ready, 1);
    // directed: fill the add bank with the unit held, then release
    hold[0] = 1;
    cycle(1, 0, 0, 1, 4, 5, 1, 16'd0);
    cycle(1, 0, 1, 2, 4, 5, 1, 16'd0);
    cycle(1, 0, 0, 3, 5, 6, 1, 16'd0);
    cycle(1, 0, 0, 7, 1, 2, 1, 16'd0);
    chk(m_busy[1] && m_busy[2] && m_busy[3], "R2", "add bank full (bench view)", 0, 1);
    hold[0] = 0;
    // dependent chain over a slow unit, then reuse of the same registers
    cycle(1, 1, 0, 4, 1, 2, 1, 16'd0);
    cycle(1, 2, 0, 4, 4, 0, 1, 16'd9);
    cycle(1, 1, 0, 1, 4, 4, 1, 16'd0);
    repeat (30) cycle(0, 0, 0, 0, 0, 0, 0, 16'd0);
    // directed R5: short load/store producer with its consumer issued behind it
    for (int n = 0; n < 20; n++) begin
      cycle(1, 2, 0, 5, 3, 0, 1, 16'(n));
      cycle(0, 0, 0, 0, 0, 0, 0, 16'd0);
      cycle(1, 0, 0, 6, 5, 5, 1, 16'd0);
      repeat (6) cycle(0, 0, 0, 0, 0, 0, 0, 16'd0);
    end
    repeat (5000) rand_cycle(1);
    for (int u = 0; u < 3; u++) hold[u] = 0;
    for (int n = 0; n < 500 && !idle_all(); n++) cycle(0, 0, 0, 0, 0, 0, 0, 16'd0);
    cycle(0, 0, 0, 0, 0, 0, 0, 16'd0);
    chk(idle_all(), "R9", "all stations released", 0, 1);
    chk(fwd_seen > 0, "R5", "bypass occurrences", fwd_seen, 1);
    for (int r = 0; r < NR; r++) chk(rf[r] == gold[r], "R8/R10", "final register value", rf[r], gold[r]);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule